// File: doc/BRIEF.md
# Vertical Sawtooth Generator with Retrace Discharge

This block produces the 12-bit code that drives a vertical deflection DAC. The code rises line by line. Each line strobe adds a programmable step to a ramp that began at a programmable start value. The ramp saturates at full scale rather than wrapping.

A vertical sync pulse ends the current ramp at once and starts a discharge phase that lasts a programmed number of line strobes. During discharge the output holds a programmable discharge value, and a low-impedance control output tells the DAC stage to lower its output impedance so the deflection can settle after retrace. The discharge value is normally set equal to the ramp start value. When the discharge phase ends, the ramp restarts from the start value.

On one field of each interlaced pair, flagged by the field-parity input, a signed offset is added to the ramp. The sum is clamped to the 12-bit range. The five settings sit in a small write-only register bank inside the block, and each setting has a defined value after reset.

Top module: `vert_ramp_gen`

## Requirements
- R1: After reset the settings are: offset 0, discharge line count 7, discharge value 1365, ramp start 1365, ramp step 4. The block starts in discharge with 7 lines to go, so `lowImpedance`=1 and `sawCode`=1365.
- R2: A `vsyncPulse` sampled high at a clock edge starts a new discharge phase from that edge, whatever phase the block was in. The line count used is the discharge line count setting held before that edge, and `lowImpedance` is 1 after the edge when that count is non-zero.
- R3: A discharge phase of N lines (N≥1) ends at the edge that samples the N-th `lineStb` of the phase. `lowImpedance` then falls to 0 and stays 0 until the next `vsyncPulse`.
- R4: While `lowImpedance` is 1, `sawCode` equals the discharge value setting, and neither the ramp start nor the offset affects it.
- R5: At the edge that ends a discharge phase, the ramp is loaded with the start value. Each later `lineStb` edge outside discharge adds the step value, and the ramp saturates at 4095.
- R6: Outside discharge, `sawCode` is the ramp plus the offset when `fieldOdd`=1 and the ramp alone when `fieldOdd`=0. The offset is a 12-bit two's-complement value from -2048 to 2047.
- R7: The ramp-plus-offset sum is clamped to 0 when negative and to 4095 when above 4095. It never wraps.
- R8: With a discharge line count of 0, a `vsyncPulse` loads the start value into the ramp at that edge. `lowImpedance` stays 0.
- R9: When `vsyncPulse` and `lineStb` are both high at the same edge, the sync takes priority. The line strobe does not count toward the new discharge phase.
- R10: A write with `cfgWrEn`=1 takes effect at the clock edge. The address selects the setting: 0 = offset, 1 = discharge line count (`cfgWrData[7:0]`), 2 = discharge value, 3 = ramp start, 4 = ramp step. Addresses 5 to 7 are not used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineStb | input | 1 | One-cycle strobe per video line |
| vsyncPulse | input | 1 | One-cycle vertical retrace pulse |
| fieldOdd | input | 1 | Field parity; 1 selects the offset field |
| cfgWrEn | input | 1 | Setting write enable |
| cfgAddr | input | 3 | Setting address |
| cfgWrData | input | 12 | Setting write data |
| sawCode | output | 12 | Code for the deflection DAC |
| lowImpedance | output | 1 | High during the discharge phase |

## Verification
Some properties hold on every cycle and are checked by assertions:
- Discharge always has at least one line left.
- Discharge can only end on a line strobe or a sync.
- A sync with a non-zero count loads that count.
- A sync with a zero count skips discharge.
- A ramp step never lowers the ramp.
- A non-negative offset on the odd field never lowers the output below the ramp.

The exact output values need the bench's scenarios. These include the line on which discharge ends, the start and step arithmetic, saturation at both ends, field selection of the offset, and sync-versus-strobe priority. The bench checks them against its own model while settings and strobes change at random.

// File: rtl/vramp_pkg.sv
package vramp_pkg;

  // Strobes from the phase control to the ramp datapath
  typedef struct packed {
    logic loadStart;
    logic stepRamp;
    logic dischActive;
  } ctlStrobes_t;

  localparam int ADDR_OFS   = 0;
  localparam int ADDR_LINES = 1;
  localparam int ADDR_DVAL  = 2;
  localparam int ADDR_START = 3;
  localparam int ADDR_STEP  = 4;

endpackage

// File: rtl/vramp_cfg.sv
module vramp_cfg #(
  parameter int DATA_W    = 12,
  parameter int LINES_W   = 8,
  parameter int ADDR_W    = 3,
  parameter int DEF_LINES = 7,
  parameter int DEF_DVAL  = 1365,
  parameter int DEF_START = 1365,
  parameter int DEF_STEP  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  output logic signed [DATA_W-1:0] ofsVal,
  output logic [LINES_W-1:0]       lineCount,
  output logic [DATA_W-1:0]        dischVal,
  output logic [DATA_W-1:0]        startVal,
  output logic [DATA_W-1:0]        stepVal
);
  import vramp_pkg::*;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ofsVal    <= '0;
      lineCount <= LINES_W'(DEF_LINES);
      dischVal  <= DATA_W'(DEF_DVAL);
      startVal  <= DATA_W'(DEF_START);
      stepVal   <= DATA_W'(DEF_STEP);
    end else if (wrEn) begin
      case (int'(addr))
        ADDR_OFS:   ofsVal    <= $signed(wrData);
        ADDR_LINES: lineCount <= wrData[LINES_W-1:0];
        ADDR_DVAL:  dischVal  <= wrData;
        ADDR_START: startVal  <= wrData;
        ADDR_STEP:  stepVal   <= wrData;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vramp_ctl.sv
module vramp_ctl #(
  parameter int LINES_W   = 8,
  parameter int DEF_LINES = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lineStb,
  input  logic                       vsyncPulse,
  input  logic [LINES_W-1:0]         cfgLines,
  output vramp_pkg::ctlStrobes_t     strobes
);
  import vramp_pkg::*;

  logic               dischQ, dischD;
  logic [LINES_W-1:0] leftQ, leftD;

  always_comb begin
    dischD            = dischQ;
    leftD             = leftQ;
    strobes.loadStart = 1'b0;
    strobes.stepRamp  = 1'b0;
    if (vsyncPulse) begin
      // Sync wins over a coincident line strobe
      if (cfgLines != '0) begin
        dischD = 1'b1;
        leftD  = cfgLines;
      end else begin
        dischD            = 1'b0;
        leftD             = '0;
        strobes.loadStart = 1'b1;
      end
    end else if (lineStb) begin
      if (dischQ) begin
        if (leftQ <= LINES_W'(1)) begin
          dischD            = 1'b0;
          leftD             = '0;
          strobes.loadStart = 1'b1;
        end else begin
          leftD = leftQ - LINES_W'(1);
        end
      end else begin
        strobes.stepRamp = 1'b1;
      end
    end
    strobes.dischActive = dischQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dischQ <= (DEF_LINES != 0);
      leftQ  <= LINES_W'(DEF_LINES);
    end else begin
      dischQ <= dischD;
      leftQ  <= leftD;
    end
  end

  // R3: an active discharge always has lines remaining
  p_lines_left_r3: assert property (@(posedge clk) disable iff (!rstN)
    dischQ |-> (leftQ != '0));

  // R3: discharge ends only on a line strobe or a sync
  p_disch_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dischQ) |-> ($past(lineStb) || $past(vsyncPulse)));

  // R2: sync with a non-zero count enters discharge with that count
  p_vsync_discharge_r2: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncPulse && cfgLines != '0) |=> (dischQ && leftQ == $past(cfgLines)));

  // R8: sync with zero count skips discharge
  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncPulse && cfgLines == '0) |=> !dischQ);

endmodule

// File: rtl/vramp_dp.sv
module vramp_dp #(
  parameter int DATA_W    = 12,
  parameter int DEF_START = 1365
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  vramp_pkg::ctlStrobes_t   strobes,
  input  logic                     fieldOdd,
  input  logic signed [DATA_W-1:0] ofsVal,
  input  logic [DATA_W-1:0]        dischVal,
  input  logic [DATA_W-1:0]        startVal,
  input  logic [DATA_W-1:0]        stepVal,
  output logic [DATA_W-1:0]        sawCode,
  output logic                     lowImpedance
);
  import vramp_pkg::*;

  localparam int SUM_W = DATA_W + 2;
  localparam logic [DATA_W-1:0] FULL = {DATA_W{1'b1}};

  logic [DATA_W-1:0]       rampQ;
  logic [DATA_W:0]         stepSum;
  logic signed [SUM_W-1:0] ofsSum;
  logic signed [SUM_W-1:0] ofsExt;
  logic [DATA_W-1:0]       fieldCode;

  // Ramp step with saturation at full scale
  assign stepSum = {1'b0, rampQ} + {1'b0, stepVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampQ <= DATA_W'(DEF_START);
    end else if (strobes.loadStart) begin
      rampQ <= startVal;
    end else if (strobes.stepRamp) begin
      rampQ <= stepSum[DATA_W] ? FULL : stepSum[DATA_W-1:0];
    end
  end

  // Field offset, clamped to the code range
  always_comb begin
    ofsExt = fieldOdd ? SUM_W'(ofsVal) : '0;
    ofsSum = $signed({2'b00, rampQ}) + ofsExt;
    if (ofsSum < 0)
      fieldCode = '0;
    else if (ofsSum > $signed({2'b00, FULL}))
      fieldCode = FULL;
    else
      fieldCode = ofsSum[DATA_W-1:0];
  end

  assign sawCode      = strobes.dischActive ? dischVal : fieldCode;
  assign lowImpedance = strobes.dischActive;

  // R5: stepping never lowers the ramp
  p_ramp_rises_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepRamp |=> (rampQ >= $past(rampQ)));

  // R7: non-negative offset never pulls the output below the ramp
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.dischActive && fieldOdd && !ofsVal[DATA_W-1]) |-> (sawCode >= rampQ));

endmodule

// File: rtl/vert_ramp_gen.sv
module vert_ramp_gen #(
  parameter int DATA_W    = 12,
  parameter int LINES_W   = 8,
  parameter int ADDR_W    = 3,
  parameter int DEF_LINES = 7,
  parameter int DEF_DVAL  = 1365,
  parameter int DEF_START = 1365,
  parameter int DEF_STEP  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStb,
  input  logic              vsyncPulse,
  input  logic              fieldOdd,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] sawCode,
  output logic              lowImpedance
);
  import vramp_pkg::*;

  logic signed [DATA_W-1:0] ofsVal;
  logic [LINES_W-1:0]       lineCount;
  logic [DATA_W-1:0]        dischVal, startVal, stepVal;
  ctlStrobes_t              strobes;

  vramp_cfg #(
    .DATA_W(DATA_W), .LINES_W(LINES_W), .ADDR_W(ADDR_W),
    .DEF_LINES(DEF_LINES), .DEF_DVAL(DEF_DVAL),
    .DEF_START(DEF_START), .DEF_STEP(DEF_STEP)
  ) i_cfg (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .addr(cfgAddr), .wrData(cfgWrData),
    .ofsVal(ofsVal), .lineCount(lineCount), .dischVal(dischVal),
    .startVal(startVal), .stepVal(stepVal)
  );

  vramp_ctl #(.LINES_W(LINES_W), .DEF_LINES(DEF_LINES)) i_ctl (
    .clk(clk), .rstN(rstN), .lineStb(lineStb), .vsyncPulse(vsyncPulse),
    .cfgLines(lineCount), .strobes(strobes)
  );

  vramp_dp #(.DATA_W(DATA_W), .DEF_START(DEF_START)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fieldOdd(fieldOdd),
    .ofsVal(ofsVal), .dischVal(dischVal), .startVal(startVal), .stepVal(stepVal),
    .sawCode(sawCode), .lowImpedance(lowImpedance)
  );

endmodule

// File: tb/test_vert_ramp_gen.sv
module test_vert_ramp_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStb = 1'b0, vsyncPulse = 1'b0, fieldOdd = 1'b0, cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [11:0] cfgWrData = '0;
  logic [11:0] sawCode;
  logic        lowImpedance;

  int nChecks = 0, nFails = 0;

  // Bench model state
  int mDisch, mLeft, mRamp, mOfs, mLines, mDv, mStart, mStep;

  vert_ramp_gen i_vert_ramp_gen (
    .clk(clk), .rstN(rstN), .lineStb(lineStb), .vsyncPulse(vsyncPulse),
    .fieldOdd(fieldOdd), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .sawCode(sawCode), .lowImpedance(lowImpedance)
  );

  always #5 clk = ~clk;

  function automatic int clampCode(input int v);
    if (v < 0) return 0;
    if (v > 4095) return 4095;
    return v;
  endfunction

  function automatic int expCode(input logic fo);
    if (mDisch != 0) return mDv;
    return clampCode(mRamp + (fo ? mOfs : 0));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle; compare before the edge, advance model at the edge
  task automatic tick(input logic ls, input logic vs, input logic we,
                      input logic [2:0] a, input logic [11:0] d);
    string tag;
    lineStb = ls; vsyncPulse = vs; cfgWrEn = we; cfgAddr = a; cfgWrData = d;
    #1;
    tag = (mDisch != 0) ? "R4" : (fieldOdd ? "R6" : "R5");
    check(tag, int'(sawCode), expCode(fieldOdd));
    check("R2", int'(lowImpedance), mDisch);
    // model next state (old settings used at this edge)
    if (vs) begin
      if (mLines != 0) begin mDisch = 1; mLeft = mLines; end
      else begin mDisch = 0; mLeft = 0; mRamp = mStart; end
    end else if (ls) begin
      if (mDisch != 0) begin
        if (mLeft <= 1) begin mDisch = 0; mLeft = 0; mRamp = mStart; end
        else mLeft = mLeft - 1;
      end else begin
        mRamp = (mRamp + mStep > 4095) ? 4095 : mRamp + mStep;
      end
    end
    if (we) begin
      case (a)
        3'd0: mOfs   = (d >= 12'd2048) ? int'(d) - 4096 : int'(d);
        3'd1: mLines = int'(d[7:0]);
        3'd2: mDv    = int'(d);
        3'd3: mStart = int'(d);
        3'd4: mStep  = int'(d);
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    lineStb = 1'b0; vsyncPulse = 1'b0; cfgWrEn = 1'b0;
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    tick(1'b0, 1'b0, 1'b1, a, d);
  endtask

  initial begin
    #(200000 * 10);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    mDisch = 1; mLeft = 7; mRamp = 1365;
    mOfs = 0; mLines = 7; mDv = 1365; mStart = 1365; mStep = 4;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check("R1", int'(lowImpedance), 1);
    check("R1", int'(sawCode), 1365);

    // R3: default 7-line discharge
    repeat (6) begin
      tick(1'b1, 1'b0, 1'b0, '0, '0);
      check("R3", int'(lowImpedance), 1);
    end
    tick(1'b1, 1'b0, 1'b0, '0, '0);
    check("R3", int'(lowImpedance), 0);
    check("R1", int'(sawCode), 1365);
    tick(1'b1, 1'b0, 1'b0, '0, '0);
    check("R5", int'(sawCode), 1369);

    // R6 / R10: offset -100 on odd field only
    wr(3'd0, 12'd3996);
    fieldOdd = 1'b1; #1;
    check("R6", int'(sawCode), 1269);
    fieldOdd = 1'b0; #1;
    check("R6", int'(sawCode), 1369);

    // R7: low clamp
    wr(3'd0, 12'd2048);
    fieldOdd = 1'b1; #1;
    check("R7", int'(sawCode), 0);

    // R2: mid-ramp sync
    wr(3'd0, 12'd2047);
    wr(3'd3, 12'd4000);
    tick(1'b0, 1'b1, 1'b0, '0, '0);
    check("R2", int'(lowImpedance), 1);
    check("R4", int'(sawCode), 1365);
    repeat (7) tick(1'b1, 1'b0, 1'b0, '0, '0);
    check("R7", int'(sawCode), 4095);
    fieldOdd = 1'b0; #1;
    check("R5", int'(sawCode), 4000);

    // R5: ramp saturation
    wr(3'd4, 12'd4095);
    tick(1'b1, 1'b0, 1'b0, '0, '0);
    check("R5", int'(sawCode), 4095);

    // R10 / R4: discharge value written
    wr(3'd2, 12'd77);
    tick(1'b0, 1'b1, 1'b0, '0, '0);
    check("R4", int'(sawCode), 77);

    // R8: zero line count
    wr(3'd1, 12'd0);
    tick(1'b0, 1'b1, 1'b0, '0, '0);
    check("R8", int'(lowImpedance), 0);
    check("R8", int'(sawCode), 4000);

    // R9: sync beats coincident line strobe
    wr(3'd1, 12'd1);
    tick(1'b1, 1'b1, 1'b0, '0, '0);
    check("R9", int'(lowImpedance), 1);
    tick(1'b1, 1'b0, 1'b0, '0, '0);
    check("R3", int'(lowImpedance), 0);

    // Random phase
    wr(3'd4, 12'd9);
    wr(3'd3, 12'd200);
    for (int i = 0; i < 6000; i++) begin
      logic ls, vs, we;
      logic [2:0] a;
      logic [11:0] d;
      ls = ($urandom % 4) == 0;
      vs = ($urandom % 150) == 0;
      we = ($urandom % 60) == 0;
      a  = 3'($urandom % 6);
      d  = 12'($urandom);
      if (a == 3'd1) d = d & 12'd15;
      if (a == 3'd4) d = d & 12'd63;
      if (vs) fieldOdd = ~fieldOdd;
      tick(ls, vs, we, a, d);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule